// File: doc/BRIEF.md
# DRAM Refresh Scheduler

This block keeps a dynamic memory alive by asking its controller for refresh cycles at a steady pace. A free-running interval counter divides the host clock so that one request is due for each row within the retention window. With the default settings the interval is 32 ms spread over 2048 rows, about 15.6 µs, or 1562 cycles at 100 MHz. When the controller is busy and cannot serve a request at once, the owed refreshes are counted, up to eight. A sticky flag records that a refresh was lost because the backlog was already full.

Two refresh styles are supported. In row-address mode the controller cycles RAS alone with CAS held high and drives a row that this block supplies from its own 11-bit counter. That counter steps once for each refresh served in this mode. In CAS-before-RAS mode the memory's own counter picks the row, so the address output is left as it is. The controller acknowledges each refresh it performs. The strobe sequencing itself belongs to the controller.

Top module: `rfs_scheduler`

## Requirements
- R1: While reset is low and just after it, `req_o` is 0, `row_o` is 0, `overflow_o` is 0 and `mode_o` is 0 (row-address mode).
- R2: The interval counter produces one refresh event every `REFRESH_CYCLES` clocks. The first event falls on the `REFRESH_CYCLES`-th rising edge after reset is released, and each later one follows `REFRESH_CYCLES` edges after the previous one. `req_o` only rises on such an edge.
- R3: `req_o` is high exactly while at least one refresh is owed. A clock edge with `ack_i` and `req_o` both high settles one owed refresh.
- R4: Up to `MAX_PEND` (default 8) refreshes are held. After that many events with no acknowledge, exactly that many acknowledges are accepted before `req_o` falls.
- R5: When an event arrives while `MAX_PEND` refreshes are already owed and none is being acknowledged, `overflow_o` goes high on that edge. It then stays high until reset.
- R6: When a refresh is acknowledged with `mode_o` = 0 (row-address mode), `row_o` increments by one. It wraps from 2047 to 0.
- R7: When a refresh is acknowledged with `mode_o` = 1 (CAS-before-RAS mode), `row_o` does not change.
- R8: `mode_o` loads `mode_sel_i` on each edge where `req_o` is low or a refresh is acknowledged. While a request waits unacknowledged, `mode_o` holds its value whatever `mode_sel_i` does.
- R9: `ack_i` has no effect while `req_o` is low. `row_o` and `req_o` are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel_i | input | 1 | Requested refresh style: 0 row-address, 1 CAS-before-RAS |
| ack_i | input | 1 | Controller has performed the offered refresh |
| req_o | output | 1 | A refresh is owed |
| mode_o | output | 1 | Style to use for the offered refresh |
| row_o | output | ROW_BITS | Row to drive in row-address mode |
| overflow_o | output | 1 | Sticky: a refresh was lost with the backlog full |

## Verification
The assertions assume that `ack_i` is only meaningful while `req_o` is high, that the controller pulses `ack_i` for one clock per refresh it performs, and that `mode_sel_i` may change at any time. The bench drives `ack_i` and `mode_sel_i` at falling edges only. It acknowledges exactly one request per pulse, except in one deliberate stretch where it holds `ack_i` high while nothing is owed. It changes the mode both while the block is idle and while a request is waiting. The refresh interval is shortened to 20 clocks, which is enough to fill the backlog, overrun it, and walk the row counter through its wrap.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

  typedef enum logic {
    RFS_ROW_ADDR = 1'b0,
    RFS_CBR      = 1'b1
  } rfs_mode_e;

  // Clocks between refresh events: retention window split over all rows.
  function automatic int refresh_interval(int clk_khz, int retain_ms, int row_bits);
    return (clk_khz * retain_ms) >> row_bits;
  endfunction

  // Width needed to count 0..n inclusive.
  function automatic int count_width(int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/rfs_tick_gen.sv
module rfs_tick_gen #(
  parameter int CYCLES = 1562
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int CW = rfs_pkg::count_width(CYCLES - 1);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/rfs_backlog.sv
module rfs_backlog #(
  parameter int MAX_PEND = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic take_i,
  output logic req_o,
  output logic lost_o,
  output logic ovf_o
);
  localparam int PW = rfs_pkg::count_width(MAX_PEND);
  localparam logic [PW-1:0] CAP = PW'(MAX_PEND);

  logic [PW-1:0] pend_q, pend_d;
  logic          full;
  logic          ovf_q;

  assign full   = (pend_q == CAP);
  assign req_o  = (pend_q != '0);
  assign lost_o = tick_i & ~take_i & full;
  assign ovf_o  = ovf_q;

  always_comb begin
    pend_d = pend_q;
    unique case ({tick_i, take_i})
      2'b10:   if (!full) pend_d = pend_q + 1'b1;
      2'b01:   pend_d = pend_q - 1'b1;
      default: pend_d = pend_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      if (lost_o) ovf_q <= 1'b1;
    end
  end
endmodule

// File: rtl/rfs_row_ctr.sv
module rfs_row_ctr #(
  parameter int ROW_BITS = 11
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step_i,
  output logic [ROW_BITS-1:0] row_o
);
  logic [ROW_BITS-1:0] row_q;

  assign row_o = row_q;

  // Natural wrap from all-ones back to zero.
  always_ff @(posedge clk) begin
    if (!rst_n)      row_q <= '0;
    else if (step_i) row_q <= row_q + 1'b1;
  end
endmodule

// File: rtl/rfs_scheduler.sv
module rfs_scheduler #(
  parameter int CLK_KHZ        = 100000,
  parameter int RETAIN_MS      = 32,
  parameter int ROW_BITS       = 11,
  parameter int MAX_PEND       = 8,
  parameter int REFRESH_CYCLES = rfs_pkg::refresh_interval(CLK_KHZ, RETAIN_MS, ROW_BITS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mode_sel_i,
  input  logic                ack_i,
  output logic                req_o,
  output logic                mode_o,
  output logic [ROW_BITS-1:0] row_o,
  output logic                overflow_o
);
  import rfs_pkg::*;

  // Named internal events, observed by the bound checker.
  logic tick_w;
  logic lost_w;
  logic take_w;
  logic step_w;

  rfs_mode_e mode_q;
  logic      req_w;

  rfs_tick_gen #(.CYCLES(REFRESH_CYCLES)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (tick_w)
  );

  rfs_backlog #(.MAX_PEND(MAX_PEND)) u_backlog (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (tick_w),
    .take_i (take_w),
    .req_o  (req_w),
    .lost_o (lost_w),
    .ovf_o  (overflow_o)
  );

  assign take_w = ack_i & req_w;
  assign step_w = take_w & (mode_q == RFS_ROW_ADDR);

  rfs_row_ctr #(.ROW_BITS(ROW_BITS)) u_row (
    .clk    (clk),
    .rst_n  (rst_n),
    .step_i (step_w),
    .row_o  (row_o)
  );

  // Style is frozen while a request waits; reloaded when idle or on service.
  always_ff @(posedge clk) begin
    if (!rst_n)                mode_q <= RFS_ROW_ADDR;
    else if (!req_w || take_w) mode_q <= rfs_mode_e'(mode_sel_i);
  end

  assign req_o  = req_w;
  assign mode_o = mode_q;
endmodule

// File: rtl/rfs_scheduler_chk.sv
module rfs_scheduler_chk #(
  parameter int ROW_BITS = 11
) (
  input logic                clk,
  input logic                rst_n,
  input logic                ack_i,
  input logic                req_o,
  input logic                mode_o,
  input logic [ROW_BITS-1:0] row_o,
  input logic                overflow_o,
  input logic                tick_w,
  input logic                lost_w
);
  AST_REQ_FROM_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_o) |-> $past(tick_w)); // R2

  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    lost_w |=> overflow_o); // R5

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_o |=> overflow_o); // R5

  AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow_o) |-> $past(lost_w)); // R5

  AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && ack_i && !mode_o) |=> (row_o == $past(row_o) + 1'b1)); // R6

  AST_ROW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_o && ack_i && !mode_o) |=> $stable(row_o)); // R7

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !ack_i) |=> $stable(mode_o)); // R8
endmodule

bind rfs_scheduler rfs_scheduler_chk #(.ROW_BITS(ROW_BITS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ack_i      (ack_i),
  .req_o      (req_o),
  .mode_o     (mode_o),
  .row_o      (row_o),
  .overflow_o (overflow_o),
  .tick_w     (tick_w),
  .lost_w     (lost_w)
);

// File: tb/test_rfs_scheduler.sv
module test_rfs_scheduler;
  localparam int CLK_PERIOD = 10;
  localparam int CYC        = 20;
  localparam int RB         = 11;
  localparam int NROWS      = 1 << RB;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode_sel_i = 1'b0;
  logic          ack_i = 1'b0;
  logic          req_o, mode_o, overflow_o;
  logic [RB-1:0] row_o;

  int checks = 0;
  int fails = 0;
  int ecount = 0;
  int model_row = 0;
  bit req_prev = 1'b0;
  int exp_q[$];

  rfs_scheduler #(.ROW_BITS(RB), .MAX_PEND(8), .REFRESH_CYCLES(CYC)) i_rfs_scheduler (
    .clk(clk), .rst_n(rst_n), .mode_sel_i(mode_sel_i), .ack_i(ack_i),
    .req_o(req_o), .mode_o(mode_o), .row_o(row_o), .overflow_o(overflow_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) if (rst_n) ecount++;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wrap_up();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  // Scoreboard monitor: each accepted acknowledge must present the expected row.
  always @(posedge clk) begin
    if (rst_n && ack_i && req_o) begin
      if (exp_q.size() == 0) chk("R3 unexpected accept", 1, 0);
      else chk("R6 row at accept", int'(row_o), exp_q.pop_front());
    end
  end

  // Request rises only on interval-aligned edges.
  always @(negedge clk) begin
    if (rst_n && req_o && !req_prev) chk("R2 rise alignment", ecount % CYC, 0);
    req_prev = req_o;
  end

  task automatic wait_edge(int n);
    wait (ecount >= n);
    @(negedge clk);
  endtask

  // Driver: at a falling edge with req_o high, push expectation and ack once.
  task automatic take_one(bit row_mode);
    exp_q.push_back(model_row);
    if (row_mode) model_row = (model_row + 1) % NROWS;
    ack_i = 1'b1;
    @(negedge clk);
    ack_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    chk("watchdog expired", 1, 0);
    wrap_up();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk("R1 req", int'(req_o), 0);
    chk("R1 row", int'(row_o), 0);
    chk("R1 overflow", int'(overflow_o), 0);
    chk("R1 mode", int'(mode_o), 0);
    rst_n = 1'b1;

    wait_edge(CYC - 1);
    chk("R2 before first event", int'(req_o), 0);
    wait_edge(CYC);
    chk("R2 first event", int'(req_o), 1);

    take_one(1'b1);
    chk("R3 req cleared", int'(req_o), 0);
    chk("R6 row stepped", int'(row_o), 1);

    wait_edge(10 * CYC - 1);
    chk("R5 no overflow at full", int'(overflow_o), 0);
    chk("R3 req while owed", int'(req_o), 1);
    wait_edge(10 * CYC);
    chk("R5 overflow set", int'(overflow_o), 1);

    n = 0;
    while (req_o) begin
      take_one(1'b1);
      n++;
    end
    chk("R4 accepted count", n, 8);
    chk("R6 row after drain", int'(row_o), 9);

    ack_i = 1'b1;
    repeat (3) @(negedge clk);
    ack_i = 1'b0;
    chk("R9 req stays low", int'(req_o), 0);
    chk("R9 row unchanged", int'(row_o), 9);
    chk("R5 overflow sticky", int'(overflow_o), 1);

    mode_sel_i = 1'b1;
    wait_edge(11 * CYC);
    chk("R3 req raised", int'(req_o), 1);
    chk("R8 mode loaded idle", int'(mode_o), 1);
    take_one(1'b0);
    chk("R7 row held in CBR", int'(row_o), 9);

    mode_sel_i = 1'b0;
    wait_edge(12 * CYC);
    chk("R8 mode row-address", int'(mode_o), 0);
    mode_sel_i = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 mode held while waiting", int'(mode_o), 0);
    take_one(1'b1);
    chk("R6 row after step", int'(row_o), 10);
    chk("R8 mode loaded on ack", int'(mode_o), 1);
    mode_sel_i = 1'b0;
    @(negedge clk);
    chk("R8 mode back to row", int'(mode_o), 0);

    while (model_row != 0) begin
      while (!req_o) @(negedge clk);
      take_one(1'b1);
    end
    chk("R6 wrap to zero", int'(row_o), 0);
    while (!req_o) @(negedge clk);
    take_one(1'b1);
    chk("R6 after wrap", int'(row_o), 1);
    chk("R3 scoreboard drained", exp_q.size(), 0);

    wrap_up();
  end
endmodule